// File: doc/BRIEF.md
# DRAM Rank Address Field Mapper

This block takes an address that has already been resolved to a single rank and splits it into the four fields that a DRAM command needs: row, column, bank address and bank group. Which address bit feeds which field bit depends on a per-DIMM page policy. In close-page mode, consecutive lines go to different bank groups and banks. In open-page mode, consecutive lines stay inside one row. Two further per-DIMM switches change the mapping. One XOR-hashes the bank and bank-group bits with higher address bits. The other moves the low bank-group bit down to a fine-grain position, which shifts the open-page column bits to fill the hole.

A caller presents the rank address and the DIMM configuration together with a one-cycle strobe. The decoded fields appear on registered outputs one clock later with a matching strobe. The fields then hold until the next strobe. The row and column bit counts trim the fields to the geometry of the fitted device.

Top module: `rank_field_mapper`

## Requirements
- R1: While `rst` is high, and after reset until the first strobe, `out_valid` is 0 and `row`, `col`, `bank` and `bank_grp` are all zero.
- R2: In close-page mode (`close_page`=1), `row` bit i, for i from 0 to 16, equals the rank-address bit at position i of this list: 15, 16, 17, 18, 20, 21, 22, 28, 10, 11, 12, 13, 29, 30, 31, 32, 33.
- R3: In close-page mode, `col` bit i, for i from 0 to 9, equals the rank-address bit at position i of this list: 3, 4, 5, 14, 19, 23, 24, 25, 26, 27. `col` bit 10 (auto-precharge) is always 1, whatever the column count.
- R4: In open-page mode, `row` bit i, for i from 0 to 16, equals the rank-address bit at position i of this list: 14, 15, 16, 20, 28, 21, 22, 23, 24, 25, 26, 27, 29, 30, 31, 32, 33.
- R5: In open-page mode, `col` bit i, for i from 0 to 9, equals rank-address bit 3+i when `fine_bank_en`=0. When `fine_bank_en`=1, it equals the bit at position i of this list: 3, 4, 5, 7, 8, 9, 10, 11, 12, 13.
- R6: `row` bit i is zero when i is not less than `row_bits` (13 to 18). `row` bit 17 is always zero. `col` bit i is zero when i is not less than `col_bits` (10 to 12), apart from the close-page auto-precharge bit. `col` bits 11 and 12 are always zero.
- R7: In close-page mode, `bank` = {a[9], a[8]} and `bank_grp` = {a[7], a[6]}. When `bank_xor_en`=1, these become {a[9]^a[28], a[8]^a[22]} and {a[7]^a[21], a[6]^a[20]}.
- R8: In open-page mode, `bank` = {a[19], a[18]}. When `bank_xor_en`=1, it becomes {a[19]^a[23], a[18]^a[22]}.
- R9: In open-page mode, `bank_grp` = {a[17], a[g]}, where g is 6 when `fine_bank_en`=1 and 13 otherwise. When `bank_xor_en`=1, `bank_grp` is XORed with {a[21], a[20]}.
- R10: `out_valid` is 1 in exactly the cycles that follow a cycle with `in_valid`=1. The fields it marks are decoded from the inputs sampled in that `in_valid` cycle.
- R11: While `in_valid`=0, changes on the address and configuration inputs have no effect on any output field. The fields hold their last decoded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: decode the present inputs |
| rank_addr | input | 34 | Rank-relative address |
| close_page | input | 1 | 1 = close-page mapping, 0 = open-page mapping |
| bank_xor_en | input | 1 | Enable XOR hashing of bank and bank-group bits |
| fine_bank_en | input | 1 | Enable fine-grain bank-group placement |
| row_bits | input | 5 | Number of row bits on the device (13 to 18) |
| col_bits | input | 4 | Number of column bits on the device (10 to 12) |
| out_valid | output | 1 | Decoded fields updated this cycle |
| row | output | 18 | Row address |
| col | output | 13 | Column address |
| bank | output | 2 | Bank address within the group |
| bank_grp | output | 2 | Bank group |

## Verification
Two functions share the low bank-group bit in the same cycle. In open-page mode, the fine-grain switch picks the source of that bit, and the XOR hash then folds address bit 20 into it. The bench drives single-hot and random addresses with both switches set together. This makes a wrong source selection or a missing hash flip the bit in ways that cancel in only a few patterns. Every output is compared on every clock against a behavioural table model. Back-to-back strobes and strobe gaps with changing inputs are interleaved, so that a field update and a hold can fall on adjacent cycles.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    localparam int ADDR_W    = 34;
    localparam int ROW_W     = 18;
    localparam int COL_W     = 13;
    localparam int BANK_W    = 2;
    localparam int POS_W     = $clog2(ADDR_W);
    localparam int ROW_TBL_N = 17;
    localparam int COL_TBL_N = 10;
    localparam int AP_BIT    = 10;
    localparam int ROWCNT_W  = 5;
    localparam int COLCNT_W  = 4;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [ROW_TBL_N-1:0][POS_W-1:0] row_tbl_t;
    typedef logic [COL_TBL_N-1:0][POS_W-1:0] col_tbl_t;

    // Packed tables: rightmost entry is field bit 0.
    localparam row_tbl_t ROW_CLOSE = {6'd33, 6'd32, 6'd31, 6'd30, 6'd29, 6'd13, 6'd12, 6'd11, 6'd10,
                                      6'd28, 6'd22, 6'd21, 6'd20, 6'd18, 6'd17, 6'd16, 6'd15};
    localparam row_tbl_t ROW_OPEN  = {6'd33, 6'd32, 6'd31, 6'd30, 6'd29, 6'd27, 6'd26, 6'd25, 6'd24,
                                      6'd23, 6'd22, 6'd21, 6'd28, 6'd20, 6'd16, 6'd15, 6'd14};
    localparam col_tbl_t COL_CLOSE = {6'd27, 6'd26, 6'd25, 6'd24, 6'd23, 6'd19, 6'd14, 6'd5, 6'd4, 6'd3};
    localparam col_tbl_t COL_OPEN  = {6'd12, 6'd11, 6'd10, 6'd9, 6'd8, 6'd7, 6'd6, 6'd5, 6'd4, 6'd3};
    localparam col_tbl_t COL_FINE  = {6'd13, 6'd12, 6'd11, 6'd10, 6'd9, 6'd8, 6'd7, 6'd5, 6'd4, 6'd3};

    typedef enum logic {PAGE_OPEN = 1'b0, PAGE_CLOSE = 1'b1} page_mode_e;

    typedef struct packed {
        page_mode_e            mode;
        logic                  xor_en;
        logic                  fine_en;
        logic [ROWCNT_W-1:0]   row_cnt;
        logic [COLCNT_W-1:0]   col_cnt;
    } dimm_cfg_t;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [BANK_W-1:0] bank;
        logic [BANK_W-1:0] bgrp;
    } dram_fields_t;

    // Two-bit field {a[hi], a[lo]}, optionally hashed with {a[xhi], a[xlo]}.
    function automatic logic [1:0] pick_pair(input logic [ADDR_W-1:0] a,
                                             input int lo, input int hi,
                                             input logic hash,
                                             input int xlo, input int xhi);
        logic [1:0] v;
        v = {a[hi], a[lo]};
        if (hash)
            v = v ^ {a[xhi], a[xlo]};
        return v;
    endfunction

endpackage

// File: rtl/bit_gather.sv
module bit_gather
    import rfm_pkg::*;
#(
    parameter int N     = 10,
    parameter int OUT_W = 13,
    parameter int CNT_W = 4
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [N-1:0][POS_W-1:0]   pos,
    input  logic [CNT_W-1:0]          count,
    output logic [OUT_W-1:0]          bits
);
    localparam int LIVE = (N < OUT_W) ? N : OUT_W;

    logic [31:0] cnt32;
    assign cnt32 = 32'(count);

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        if (i < LIVE) begin : g_live
            assign bits[i] = (cnt32 > 32'(i)) ? addr[pos[i]] : 1'b0;
        end else begin : g_zero
            assign bits[i] = 1'b0;
        end
    end
endmodule

// File: rtl/bank_hash.sv
module bank_hash
    import rfm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  page_mode_e        mode,
    input  logic              xor_en,
    input  logic              fine_en,
    output logic [BANK_W-1:0] bank,
    output logic [BANK_W-1:0] bgrp
);
    logic [1:0] bank_close, bgrp_close, bank_open, bgrp_open;
    int         bg_lo;

    always_comb begin
        bg_lo      = fine_en ? 6 : 13;
        bank_close = pick_pair(addr, 8, 9, xor_en, 22, 28);
        bgrp_close = pick_pair(addr, 6, 7, xor_en, 20, 21);
        bank_open  = pick_pair(addr, 18, 19, xor_en, 22, 23);
        bgrp_open  = pick_pair(addr, bg_lo, 17, xor_en, 20, 21);
        if (mode == PAGE_CLOSE) begin
            bank = bank_close;
            bgrp = bgrp_close;
        end else begin
            bank = bank_open;
            bgrp = bgrp_open;
        end
    end
endmodule

// File: rtl/rank_field_mapper.sv
module rank_field_mapper
    import rfm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [ADDR_W-1:0]    rank_addr,
    input  logic                 close_page,
    input  logic                 bank_xor_en,
    input  logic                 fine_bank_en,
    input  logic [ROWCNT_W-1:0]  row_bits,
    input  logic [COLCNT_W-1:0]  col_bits,
    output logic                 out_valid,
    output logic [ROW_W-1:0]     row,
    output logic [COL_W-1:0]     col,
    output logic [BANK_W-1:0]    bank,
    output logic [BANK_W-1:0]    bank_grp
);
    dimm_cfg_t    cfg;
    row_tbl_t     row_pos;
    col_tbl_t     col_pos;
    logic [ROW_W-1:0]  row_raw;
    logic [COL_W-1:0]  col_raw;
    logic [BANK_W-1:0] bank_d, bgrp_d;
    dram_fields_t next_f, cur_f;
    logic         vld_q;

    always_comb begin
        cfg.mode    = close_page ? PAGE_CLOSE : PAGE_OPEN;
        cfg.xor_en  = bank_xor_en;
        cfg.fine_en = fine_bank_en;
        cfg.row_cnt = row_bits;
        cfg.col_cnt = col_bits;
    end

    always_comb begin
        if (cfg.mode == PAGE_CLOSE) begin
            row_pos = ROW_CLOSE;
            col_pos = COL_CLOSE;
        end else begin
            row_pos = ROW_OPEN;
            col_pos = cfg.fine_en ? COL_FINE : COL_OPEN;
        end
    end

    bit_gather #(.N(ROW_TBL_N), .OUT_W(ROW_W), .CNT_W(ROWCNT_W)) u_row (
        .addr (rank_addr),
        .pos  (row_pos),
        .count(cfg.row_cnt),
        .bits (row_raw)
    );

    bit_gather #(.N(COL_TBL_N), .OUT_W(COL_W), .CNT_W(COLCNT_W)) u_col (
        .addr (rank_addr),
        .pos  (col_pos),
        .count(cfg.col_cnt),
        .bits (col_raw)
    );

    bank_hash u_bank (
        .addr   (rank_addr),
        .mode   (cfg.mode),
        .xor_en (cfg.xor_en),
        .fine_en(cfg.fine_en),
        .bank   (bank_d),
        .bgrp   (bgrp_d)
    );

    always_comb begin
        next_f.row  = row_raw;
        next_f.col  = col_raw;
        if (cfg.mode == PAGE_CLOSE)
            next_f.col[AP_BIT] = 1'b1;
        next_f.bank = bank_d;
        next_f.bgrp = bgrp_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cur_f <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                cur_f <= next_f;
        end
    end

    assign out_valid = vld_q;
    assign row       = cur_f.row;
    assign col       = cur_f.col;
    assign bank      = cur_f.bank;
    assign bank_grp  = cur_f.bgrp;

    // R10: strobe timing
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_no_stray_valid_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R11: fields hold without a strobe
    assert_hold_fields_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(row) && $stable(col) && $stable(bank) && $stable(bank_grp)));

    // R6: trimming to the configured geometry
    assert_row_trim_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((row >> $past(row_bits)) == '0));
    assert_col_trim_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !close_page) |=> ((col >> $past(col_bits)) == '0));

    // R3: auto-precharge flag in close-page mode
    assert_ap_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && close_page) |=> col[AP_BIT]);
endmodule

// File: tb/tb_rank_field_mapper.sv
module tb_rank_field_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [33:0] rank_addr;
    logic        close_page, bank_xor_en, fine_bank_en;
    logic [4:0]  row_bits;
    logic [3:0]  col_bits;
    logic        out_valid;
    logic [17:0] row;
    logic [12:0] col;
    logic [1:0]  bank, bank_grp;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    rank_field_mapper dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .rank_addr(rank_addr),
        .close_page(close_page), .bank_xor_en(bank_xor_en), .fine_bank_en(fine_bank_en),
        .row_bits(row_bits), .col_bits(col_bits), .out_valid(out_valid),
        .row(row), .col(col), .bank(bank), .bank_grp(bank_grp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int crow [17] = '{15, 16, 17, 18, 20, 21, 22, 28, 10, 11, 12, 13, 29, 30, 31, 32, 33};
    int orow [17] = '{14, 15, 16, 20, 28, 21, 22, 23, 24, 25, 26, 27, 29, 30, 31, 32, 33};
    int ccol [10] = '{3, 4, 5, 14, 19, 23, 24, 25, 26, 27};
    int ocol [10] = '{3, 4, 5, 6, 7, 8, 9, 10, 11, 12};
    int fcol [10] = '{3, 4, 5, 7, 8, 9, 10, 11, 12, 13};

    // Expected-state model
    logic        e_vld;
    logic [17:0] e_row;
    logic [12:0] e_col;
    logic [1:0]  e_bank, e_bg;
    string       e_mode;
    bit          in_reset_phase;

    task automatic model(input logic [33:0] a, input logic cp, x, f,
                         input int rc, input int cc);
        e_row = '0; e_col = '0;
        for (int i = 0; i < 17; i++)
            if (i < rc) e_row[i] = cp ? a[crow[i]] : a[orow[i]];
        for (int i = 0; i < 10; i++)
            if (i < cc) e_col[i] = cp ? a[ccol[i]] : (f ? a[fcol[i]] : a[ocol[i]]);
        if (cp) begin
            e_col[10] = 1'b1;
            e_bank = {a[9], a[8]} ^ (x ? {a[28], a[22]} : 2'b00);
            e_bg   = {a[7], a[6]} ^ (x ? {a[21], a[20]} : 2'b00);
            e_mode = "close";
        end else begin
            e_bank = {a[19], a[18]} ^ (x ? {a[23], a[22]} : 2'b00);
            e_bg   = {a[17], (f ? a[6] : a[13])} ^ (x ? {a[21], a[20]} : 2'b00);
            e_mode = "open";
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            e_vld <= 1'b0;
            e_row = '0; e_col = '0; e_bank = '0; e_bg = '0;
        end else begin
            e_vld <= in_valid;
            if (in_valid)
                model(rank_addr, close_page, bank_xor_en, fine_bank_en,
                      int'(row_bits), int'(col_bits));
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (mode %s, t=%0t)", req, act, exp, e_mode, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done && e_vld !== 1'bx) begin
            if (in_reset_phase) begin
                chk("R1 valid", 32'(out_valid), 32'(0));
                chk("R1 fields", {row, col, bank, bank_grp}, 32'(0));
            end else begin
                chk("R10 out_valid", 32'(out_valid), 32'(e_vld));
                if (e_mode == "close") begin
                    chk("R2/R6 row", 32'(row), 32'(e_row));
                    chk("R3/R6 col", 32'(col), 32'(e_col));
                    chk("R7 bank", 32'(bank), 32'(e_bank));
                    chk("R7 bank_grp", 32'(bank_grp), 32'(e_bg));
                end else begin
                    chk("R4/R6 row", 32'(row), 32'(e_row));
                    chk("R5/R6 col", 32'(col), 32'(e_col));
                    chk("R8 bank", 32'(bank), 32'(e_bank));
                    chk("R9 bank_grp", 32'(bank_grp), 32'(e_bg));
                end
            end
        end
    end

    task automatic drive(input logic v, input logic [33:0] a, input logic cp, x, f,
                         input int rc, input int cc);
        @(negedge clk);
        in_valid = v; rank_addr = a; close_page = cp; bank_xor_en = x;
        fine_bank_en = f; row_bits = 5'(rc); col_bits = 4'(cc);
    endtask

    initial begin
        e_mode = "open";
        in_reset_phase = 1'b1;
        rst = 1'b1; in_valid = 1'b0; rank_addr = '0; close_page = 1'b0;
        bank_xor_en = 1'b0; fine_bank_en = 1'b0; row_bits = 5'd18; col_bits = 4'd12;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset, inputs wiggling without strobe
        drive(1'b0, 34'h3_FFFF_FFFF, 1'b1, 1'b1, 1'b1, 18, 12);
        drive(1'b0, 34'h0, 1'b0, 1'b0, 1'b0, 13, 10);
        @(negedge clk);
        in_reset_phase = 1'b0;

        // R2-R9: single-hot addresses in every mode combination, full geometry
        for (int m = 0; m < 8; m++)
            for (int b = 0; b < 34; b++)
                drive(1'b1, 34'(1) << b, m[0], m[1], m[2], 18, 12);

        // R6: all-ones address with every geometry
        for (int rc = 13; rc <= 18; rc++)
            for (int cc = 10; cc <= 12; cc++)
                for (int m = 0; m < 2; m++)
                    drive(1'b1, 34'h3_FFFF_FFFF, m[0], 1'b0, m[0], rc, cc);

        // R9 + hash: fine-grain and XOR together, patterns on bits 6, 13, 20
        drive(1'b1, 34'h0_0010_0040, 1'b0, 1'b1, 1'b1, 16, 10);
        drive(1'b1, 34'h0_0010_2000, 1'b0, 1'b1, 1'b1, 16, 10);
        drive(1'b1, 34'h0_0010_2000, 1'b0, 1'b1, 1'b0, 16, 10);
        drive(1'b1, 34'h0_0030_2040, 1'b0, 1'b1, 1'b0, 16, 10);

        // R10/R11: random traffic with gaps where inputs change
        for (int n = 0; n < 1500; n++) begin
            logic [33:0] a;
            logic [2:0]  m;
            a = {$urandom(), $urandom()};
            m = 3'($urandom());
            drive(($urandom() % 3) != 0, a, m[0], m[1], m[2],
                  13 + int'($urandom() % 6), 10 + int'($urandom() % 3));
        end
        drive(1'b0, 34'h1_2345_6789, 1'b1, 1'b1, 1'b1, 13, 10);
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule